// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit control and status registers sitting on a simple memory-mapped slave bus. The bus window is 1 KB, little-endian, and accepts only aligned full-word accesses. The bank holds the following registers:

- system control
- clock control
- power management
- a peripheral clock divider
- two peripheral clock-gate registers
- memory control
- system status
- an extended reset register
- event enable
- revision
- interrupt enable
- four ECC status registers

Each register comes out of reset with a fixed value. Most registers store whatever is written to them. Three registers have write side effects:

- **System control** keeps only two of the written bits and always reads with its checksum-pass status bits set.
- **Clock control** always reads with its clock-ready bit set after a write.
- **The reset register** is a command port rather than storage. A write produces, one cycle later, a one-cycle pulse on each selected per-peripheral reset line and, if requested, a whole-system reset request. Two group bits expand into fixed sets of peripheral resets.

An access to an unmapped offset, to a misaligned address, or with byte enables other than all four is refused. A refused read returns zero, a refused write changes nothing, and the error flag pulses. Read data and the error flag are registered and appear in the cycle after the request.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, reads return these values (offset: value). 0x00 system control = 0x00021002. 0x08 clock control = 0x3E140008. 0x0C power = 0x0003F000. 0x14 and 0x24 clock gates = 0xFFFFFFFF. 0x18 memory control = 0x5. 0x2C revision = 0xA1. Every other mapped register (0x04 to 0x40 in word steps) = 0. All outputs are 0 during and just after reset.
- R2: An access whose byte enables are not 4'hF, or whose address has bits 1:0 nonzero, changes no register and fires no reset. A read of this kind returns 0, and bus_err is 1 in the following cycle.
- R3: A write to system control (0x00) stores only data bits 17:16; the register then reads as those bits OR 0x00001002.
- R4: A write to clock control (0x08) stores the written value with bit 13 (clock ready) forced to 1.
- R5: Writing bit 31 of the reset register (0x04) sets sys_rst_req for exactly the one cycle after the write.
- R6: Writing bit 30 of the reset register pulses periph_rst = 0x07FFF for one cycle after the write. The bit positions are: 0-2 UART0-2, 3 ADC, 4 accelerator, 5 TRNG, 6 RTC, 7 I2C0, 8 SPI1, 9-12 timers 0-3, 13 watchdog 0, 14 DMA, 15-16 GPIO0-1. Any individual bits written alongside are replaced by the set.
- R7: Writing bit 29 of the reset register pulses periph_rst = 0x1DFFF, which is the bit-30 set without the watchdog and with both GPIOs. If bits 29 and 30 are both set, this set wins.
- R8: A full-word access to an offset beyond 0x40 returns 0 on read and is ignored on write; bus_err is 1 in the cycle after the access.
- R9: With no group bit set, reset-register data bits 16:0 pulse the matching periph_rst bits for one cycle. The reset register always reads as 0.
- R10: The plain registers (0x0C to 0x40, including revision) store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address within the window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Refused-access flag, the cycle after the access |
| sys_rst_req | output | 1 | Whole-system reset request pulse |
| periph_rst | output | 17 | Per-peripheral reset pulses |

## Verification
Reset-register writes are tried with several data patterns. The first is the system bit alone, which shows that the system request does not leak onto peripheral lines. The next are the peripheral group bit with a stray individual bit and then the soft group bit alone, which separate the two fixed sets by the watchdog and GPIO positions. Both group bits together are written to show which set wins, and two scattered individual bits show the plain one-to-one mapping. Masked-register writes use all-ones, all-zeros and a mixed pattern, so that forced bits can be told apart from stored bits. Refused accesses cover partial byte enables, a misaligned address and offsets just past and far past the map, each followed by a read of the register the access could have disturbed.

// File: rtl/sysctl_pkg.sv
// Shared constants and per-register reset/write behaviour of the system
// control register bank. Assumes a 32-bit data path and word-indexed map.
package sysctl_pkg;

    localparam int DATA_W     = 32;
    localparam int NUM_REGS   = 17;
    localparam int NUM_PERIPH = 17;

    // Word indices (byte offset = index * 4)
    localparam int IDX_SYS     = 0;
    localparam int IDX_RST     = 1;
    localparam int IDX_CLK     = 2;
    localparam int IDX_PWR     = 3;
    localparam int IDX_PDIV    = 4;
    localparam int IDX_GATE0   = 5;
    localparam int IDX_MEMCTL  = 6;
    localparam int IDX_STAT    = 7;
    localparam int IDX_RSTX    = 8;
    localparam int IDX_GATE1   = 9;
    localparam int IDX_EVT     = 10;
    localparam int IDX_REV     = 11;
    localparam int IDX_INTEN   = 12;
    localparam int IDX_ECCERR  = 13;
    localparam int IDX_ECCDET  = 14;
    localparam int IDX_ECCIEN  = 15;
    localparam int IDX_ECCADDR = 16;

    localparam logic [DATA_W-1:0] SYS_KEEP_MASK = 32'h0003_0000;
    localparam logic [DATA_W-1:0] SYS_FORCE_SET = 32'h0000_1002;
    localparam logic [DATA_W-1:0] CLK_READY_SET = 32'h0000_2000;

    // Reset-register command bits
    localparam int CMD_SYSTEM = 31;
    localparam int CMD_PERIPH = 30;
    localparam int CMD_SOFT   = 29;

    localparam logic [NUM_PERIPH-1:0] GROUP_PERIPH = 17'h07FFF;
    localparam logic [NUM_PERIPH-1:0] GROUP_SOFT   = 17'h1DFFF;

    // Value each register takes under reset.
    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        case (idx)
            IDX_SYS:    return 32'h0002_1002;
            IDX_CLK:    return 32'h3E14_0008;
            IDX_PWR:    return 32'h0003_F000;
            IDX_GATE0:  return 32'hFFFF_FFFF;
            IDX_GATE1:  return 32'hFFFF_FFFF;
            IDX_MEMCTL: return 32'h0000_0005;
            IDX_REV:    return 32'h0000_00A1;
            default:    return '0;
        endcase
    endfunction

    // Value stored when a register is written with the given data.
    function automatic logic [DATA_W-1:0] reg_next(input int idx,
                                                    input logic [DATA_W-1:0] wdata);
        case (idx)
            IDX_SYS: return (wdata & SYS_KEEP_MASK) | SYS_FORCE_SET;
            IDX_CLK: return wdata | CLK_READY_SET;
            IDX_RST: return '0;
            default: return wdata;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: turns a bus request into a word index and legal/refused
// qualifiers. Assumes byte addressing with word-aligned registers.
module sysctl_decode #(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 17,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    output logic [IDX_W-1:0]  word_idx,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              refused
);
    logic legal;

    // Classify the access as legal (full aligned word in the map) or refused.
    always_comb begin
        word_idx = bus_addr[ADDR_W-1:2];
        legal    = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00)
                   && (word_idx < IDX_W'(NUM_REGS));
        rd_ok    = bus_sel && !bus_wr && legal;
        wr_ok    = bus_sel &&  bus_wr && legal;
        refused  = bus_sel && !legal;
    end
endmodule

// File: rtl/sysctl_regfile.sv
// Register storage with per-register reset values and write masking.
// Assumes the index has already been checked against the map.
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    // Load reset values, or apply a masked write to the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_reset(i);
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (idx == IDX_W'(i)) regs[i] <= reg_next(i, wdata);
        end
    end

    // Select the addressed register for reading.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (idx == IDX_W'(i)) rd_val = regs[i];
    end
endmodule

// File: rtl/sysctl_rst_fanout.sv
// Expands a reset-register write into registered one-cycle reset pulses.
// Assumes fire is high only for a legal write to the reset register.
module sysctl_rst_fanout
    import sysctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [2:0]            cmd_bits,   // {system, periph, soft}
    input  logic [NUM_PERIPH-1:0] indiv_bits,
    output logic                  sys_req,
    output logic [NUM_PERIPH-1:0] pulses
);
    logic [NUM_PERIPH-1:0] expanded;

    // Soft group wins, then peripheral group, else individual bits.
    always_comb begin
        if (cmd_bits[0])      expanded = GROUP_SOFT;
        else if (cmd_bits[1]) expanded = GROUP_PERIPH;
        else                  expanded = indiv_bits;
    end

    // Register the system request as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_req <= 1'b0;
        else        sys_req <= fire && cmd_bits[2];
    end

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_line
        // One flop per peripheral line; high only the cycle after the write.
        always_ff @(posedge clk) begin
            if (!rst_n) pulses[p] <= 1'b0;
            else        pulses[p] <= fire && expanded[p];
        end
    end
endmodule

// File: rtl/sysctl_regbank.sv
// Top of the system control register bank: decode, storage, reset fan-out
// and registered read/error response. Assumes one request per cycle.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [3:0]            bus_be,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_err,
    output logic                  sys_rst_req,
    output logic [NUM_PERIPH-1:0] periph_rst
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word_idx;
    logic              rd_ok, wr_ok, refused;
    logic [DATA_W-1:0] rd_val;
    logic              rst_fire;

    sysctl_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .bus_be  (bus_be),
        .word_idx(word_idx),
        .rd_ok   (rd_ok),
        .wr_ok   (wr_ok),
        .refused (refused)
    );

    sysctl_regfile #(.IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ok),
        .idx   (word_idx),
        .wdata (bus_wdata),
        .rd_val(rd_val)
    );

    assign rst_fire = wr_ok && (word_idx == IDX_W'(IDX_RST));

    sysctl_rst_fanout u_fanout (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (rst_fire),
        .cmd_bits  ({bus_wdata[CMD_SYSTEM], bus_wdata[CMD_PERIPH], bus_wdata[CMD_SOFT]}),
        .indiv_bits(bus_wdata[NUM_PERIPH-1:0]),
        .sys_req   (sys_rst_req),
        .pulses    (periph_rst)
    );

    // Registered read response: legal reads return data, refused ones zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               bus_rdata <= '0;
        else if (rd_ok)           bus_rdata <= rd_val;
        else if (bus_sel && !bus_wr) bus_rdata <= '0;
    end

    // Registered one-cycle error flag for refused accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= refused;
    end
endmodule

// File: rtl/sysctl_regbank_chk.sv
// Port-level property checker for the register bank, bound to the top.
module sysctl_regbank_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              sys_rst_req,
    input logic [16:0]       periph_rst
);
    logic full_word, rst_wr, sys_rd, rst_rd, far_rd;

    // Request qualifiers observed at the ports.
    always_comb begin
        full_word = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
        rst_wr    = full_word && bus_wr  && (bus_addr == ADDR_W'(4));
        rst_rd    = full_word && !bus_wr && (bus_addr == ADDR_W'(4));
        sys_rd    = full_word && !bus_wr && (bus_addr == ADDR_W'(0));
        far_rd    = full_word && !bus_wr && (bus_addr > ADDR_W'(64));
    end

    AST_SYSCTL_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sys_rd) |-> ((bus_rdata & ~32'h0003_1002) == 32'h0) && bus_rdata[12] && bus_rdata[1]); // R3

    AST_SYSREQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(rst_wr && bus_wdata[31])); // R5

    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_rst != 17'h0) |-> $past(rst_wr)); // R9

    AST_PERIPH_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_wr && bus_wdata[30] && !bus_wdata[29]) |-> (periph_rst == 17'h07FFF)); // R6

    AST_SOFT_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_wr && bus_wdata[29]) |-> (periph_rst == 17'h1DFFF)); // R7

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(far_rd) |-> (bus_err && bus_rdata == 32'h0)); // R8

    AST_RST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_rd) |-> (bus_rdata == 32'h0 && !bus_err)); // R9

    AST_PARTIAL_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && bus_wr && bus_be != 4'hF) |-> (bus_err && !sys_rst_req && periph_rst == 17'h0)); // R2
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .sys_rst_req(sys_rst_req),
    .periph_rst (periph_rst)
);

// File: tb/sysctl_regbank_tb.sv
`timescale 1ns/1ps
module sysctl_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [9:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        sys_rst_req;
    logic [16:0] periph_rst;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    localparam int WATCHDOG = 20000;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles++;

    sysctl_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .sys_rst_req(sys_rst_req), .periph_rst(periph_rst)
    );

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'h000, 32'h0, 32'h0002_1002, 4'd1},  // R1
        '{1'b0, 10'h008, 32'h0, 32'h3E14_0008, 4'd1},  // R1
        '{1'b0, 10'h00C, 32'h0, 32'h0003_F000, 4'd1},  // R1
        '{1'b0, 10'h014, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1
        '{1'b0, 10'h024, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1
        '{1'b0, 10'h018, 32'h0, 32'h0000_0005, 4'd1},  // R1
        '{1'b0, 10'h02C, 32'h0, 32'h0000_00A1, 4'd1},  // R1
        '{1'b0, 10'h040, 32'h0, 32'h0000_0000, 4'd1},  // R1
        '{1'b1, 10'h000, 32'hFFFF_FFFF, 32'h0, 4'd3},  // R3
        '{1'b0, 10'h000, 32'h0, 32'h0003_1002, 4'd3},  // R3
        '{1'b1, 10'h000, 32'h0, 32'h0, 4'd3},          // R3
        '{1'b0, 10'h000, 32'h0, 32'h0000_1002, 4'd3},  // R3
        '{1'b1, 10'h008, 32'h0, 32'h0, 4'd4},          // R4
        '{1'b0, 10'h008, 32'h0, 32'h0000_2000, 4'd4},  // R4
        '{1'b1, 10'h008, 32'h1234_5678, 32'h0, 4'd4},  // R4
        '{1'b0, 10'h008, 32'h0, 32'h1234_7678, 4'd4},  // R4
        '{1'b1, 10'h02C, 32'hDEAD_BEEF, 32'h0, 4'd10}, // R10
        '{1'b0, 10'h02C, 32'h0, 32'hDEAD_BEEF, 4'd10}, // R10
        '{1'b1, 10'h040, 32'hCAFE_F00D, 32'h0, 4'd10}, // R10
        '{1'b0, 10'h040, 32'h0, 32'hCAFE_F00D, 4'd10}, // R10
        '{1'b1, 10'h010, 32'h0000_0F0F, 32'h0, 4'd10}, // R10
        '{1'b0, 10'h010, 32'h0, 32'h0000_0F0F, 4'd10}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus access; returns at the falling edge after the response edge.
    task automatic access(input logic wr, input logic [9:0] addr,
                          input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_be = be; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        wait (cycles >= WATCHDOG);
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_be = 4'hF; bus_wdata = '0;
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1", {bus_err, sys_rst_req, periph_rst}, 32'h0);
        check("R1", bus_rdata, 32'h0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, 4'hF, VECS[i].data);
            if (!VECS[i].wr)
                check($sformatf("R%0d", VECS[i].req), bus_rdata, VECS[i].exp);
            if (bus_err) begin
                n_fails++;
                $display("FAIL R%0d: actual err 1 expected 0", VECS[i].req);
            end
        end

        // R5: system bit only
        access(1'b1, 10'h004, 4'hF, 32'h8000_0000);
        check("R5", {14'h0, sys_rst_req, periph_rst}, {14'h0, 1'b1, 17'h0});
        @(negedge clk);
        check("R5", {31'h0, sys_rst_req}, 32'h0);

        // R6: peripheral group plus a stray individual bit
        access(1'b1, 10'h004, 4'hF, 32'h4001_0000);
        check("R6", {15'h0, periph_rst}, 32'h0000_7FFF);
        check("R6", {31'h0, sys_rst_req}, 32'h0);
        @(negedge clk);
        check("R6", {15'h0, periph_rst}, 32'h0);

        // R7: soft group alone, then both group bits
        access(1'b1, 10'h004, 4'hF, 32'h2000_0000);
        check("R7", {15'h0, periph_rst}, 32'h0001_DFFF);
        access(1'b1, 10'h004, 4'hF, 32'h6000_0000);
        check("R7", {15'h0, periph_rst}, 32'h0001_DFFF);

        // R9: individual bits and read-back of the reset register
        access(1'b1, 10'h004, 4'hF, 32'h0001_0020);
        check("R9", {15'h0, periph_rst}, 32'h0001_0020);
        access(1'b0, 10'h004, 4'hF, 32'h0);
        check("R9", bus_rdata, 32'h0);
        check("R9", {15'h0, periph_rst}, 32'h0);

        // R8: unmapped offsets
        access(1'b1, 10'h044, 4'hF, 32'h1111_1111);
        check("R8", {31'h0, bus_err}, 32'h1);
        access(1'b0, 10'h040, 4'hF, 32'h0);
        check("R8", bus_rdata, 32'hCAFE_F00D);
        access(1'b0, 10'h044, 4'hF, 32'h0);
        check("R8", {bus_rdata[30:0], bus_err}, 32'h1);
        access(1'b0, 10'h3FC, 4'hF, 32'h0);
        check("R8", {bus_rdata[30:0], bus_err}, 32'h1);

        // R2: partial byte enables and misaligned addresses
        access(1'b1, 10'h000, 4'h1, 32'hFFFF_FFFF);
        check("R2", {31'h0, bus_err}, 32'h1);
        access(1'b0, 10'h000, 4'hF, 32'h0);
        check("R2", bus_rdata, 32'h0000_1002);
        access(1'b0, 10'h002, 4'hF, 32'h0);
        check("R2", {bus_rdata[30:0], bus_err}, 32'h1);
        access(1'b0, 10'h008, 4'h3, 32'h0);
        check("R2", {bus_rdata[30:0], bus_err}, 32'h1);
        access(1'b1, 10'h004, 4'h7, 32'hE000_FFFF);
        check("R2", {14'h0, sys_rst_req, periph_rst}, 32'h0);
        access(1'b1, 10'h006, 4'hF, 32'hE000_FFFF);
        check("R2", {14'h0, sys_rst_req, periph_rst}, 32'h0);

        finish_run();
    end
endmodule